// File: doc/BRIEF.md
# Repeatable Alarm Match Unit

This block watches the running calendar time of a real-time clock and raises an alarm when that time equals a programmed alarm setting. The clock core supplies the current second, minute, hour, date and month as BCD bytes, plus a single-cycle strobe once per second. The alarm is evaluated only on that strobe. A five-bit repeat code masks fields out of the comparison. This allows alarms that fire once a month, once a day, once an hour, once a minute or once a second.

A host programs the alarm bytes, the repeat code and two enables through a byte-wide register port. When a match occurs, the block sets an alarm flag. If the flag's enable is set, it also pulls an active-low interrupt line. The host clears the interrupt in two steps: the first read of the flags register releases the line, and a second read clears the flag. A backup-mode input marks periods when the host is unpowered. During those periods the interrupt may only be driven if a separate backup enable is also set. Reset clears both enables, so an alarm that arrives just after reset is recorded in the flag only.

Top module: `alm_match_unit`

## Requirements
- R1: Alarm bytes live at register addresses 0 to 4 (second, minute, hour, date, month). The repeat code is at address 5, bits 4:0, with bit 0 as the seconds-ignore bit and bit 4 as the month-ignore bit. The accepted codes, written bit 4 down to bit 0, are 00000, 10000, 11000, 11100, 11110 and 11111. In an accepted code, each set bit drops its field (bit 0 second, bit 1 minute, bit 2 hour, bit 3 date, bit 4 month) from the comparison, and every remaining field must equal the current time.
- R2: Any repeat code other than the accepted ones ignores every field, so the alarm fires on every tick.
- R3: A matching tick sets the alarm flag, visible as bit 6 of the flags register at address 7, on the clock edge that samples the tick.
- R4: irq_n is low only while the alarm flag is set, the interrupt is not released, and the alarm enable (address 6, bit 0) is 1.
- R5: A read of address 7 while the flag is set and the interrupt is pending releases irq_n (high after that edge) and leaves the flag set. The next read of address 7 clears the flag. A read returns the flag value from before its own effect.
- R6: While backup is 1, irq_n can go low only if the backup enable (address 6, bit 1) is also 1.
- R7: After reset, irq_n is high and every register reads 0, including both enables and the flag.
- R8: When the alarm date byte is 0 and repeat bits 3:0 are all 0, no tick sets the flag.
- R9: Without a tick, no comparison takes place. A new match on a later tick re-arms an interrupt that has already been released.
- R10: Writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick | input | 1 | One-cycle strobe once per second |
| backup | input | 1 | High while the host is unpowered |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| reg_sel | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_sel, combinational |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Every state change is registered on exactly one rising edge. A tick, a write or a read therefore shows its effect one edge after it is presented. irq_n and reg_rdata are decoded combinationally from that state, so no further delay is added. The bench drives each stimulus on a falling edge and holds it through one rising edge. It checks irq_n at the next falling edge. It samples reg_rdata 1 ns after presenting an address, which is before the read's own side effect takes hold. The flag sequence is therefore checked read by read: flag seen, flag seen again, then cleared.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NF      = 5;   // compared fields
    localparam int DW      = 8;   // byte width
    localparam int AW      = 3;   // register address width
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DATE  = 3;
    localparam int F_MONTH = 4;
    localparam int A_RPT   = NF;
    localparam int A_EN    = NF + 1;
    localparam int A_FLAGS = NF + 2;
    localparam int AF_BIT  = 6;

    typedef struct packed {
        logic [NF-1:0][DW-1:0] alm;
        logic [NF-1:0]         rpt;
        logic                  afe;
        logic                  abe;
        logic                  af;
        logic                  rel;
    } alm_state_t;
endpackage

// File: rtl/alm_repeat_decode.sv
module alm_repeat_decode #(
    parameter int NF = 5
) (
    input  logic [NF-1:0] rpt,
    output logic [NF-1:0] ignore,
    output logic          code_ok
);
    logic [NF:0] inv_w;
    logic [NF:0] inc_w;

    // accepted codes are a run of ones from the top: inverse is a run of ones from bit 0
    always_comb begin
        inv_w   = {1'b0, ~rpt};
        inc_w   = inv_w + 1'b1;
        code_ok = ((inv_w & inc_w) == '0);
        ignore  = code_ok ? rpt : '1;
    end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int NF = 5,
    parameter int DW = 8
) (
    input  logic [NF-1:0][DW-1:0] cur,
    input  logic [NF-1:0][DW-1:0] alm,
    input  logic [NF-1:0]         ignore,
    output logic                  match
);
    logic [NF-1:0] hit_w;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign hit_w[i] = ignore[i] | (cur[i] == alm[i]);
    end

    assign match = &hit_w;
endmodule

// File: rtl/alm_match_unit.sv
module alm_match_unit
    import alm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          backup,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    input  logic [DW-1:0] cur_month,
    input  logic [AW-1:0] reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_n
);
    alm_state_t state_d, state_q;

    logic [NF-1:0][DW-1:0] cur_w;
    logic [NF-1:0]         ignore_w;
    logic                  code_ok_w;
    logic                  match_w;
    logic                  disabled_w;
    logic                  fire_w;

    assign cur_w = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

    alm_repeat_decode #(.NF(NF)) u_decode (
        .rpt     (state_q.rpt),
        .ignore  (ignore_w),
        .code_ok (code_ok_w)
    );

    alm_field_cmp #(.NF(NF), .DW(DW)) u_cmp (
        .cur    (cur_w),
        .alm    (state_q.alm),
        .ignore (ignore_w),
        .match  (match_w)
    );

    assign disabled_w = (state_q.alm[F_DATE] == '0) && (state_q.rpt[NF-2:0] == '0);
    assign fire_w     = tick && match_w && !disabled_w;

    always_comb begin
        state_d = state_q;
        if (reg_wr) begin
            for (int i = 0; i < NF; i++) begin
                if (reg_sel == AW'(i)) state_d.alm[i] = reg_wdata;
            end
            if (reg_sel == AW'(A_RPT)) state_d.rpt = reg_wdata[NF-1:0];
            if (reg_sel == AW'(A_EN)) begin
                state_d.afe = reg_wdata[0];
                state_d.abe = reg_wdata[1];
            end
        end
        if (reg_rd && reg_sel == AW'(A_FLAGS) && state_q.af) begin
            if (!state_q.rel) begin
                state_d.rel = 1'b1;
            end else begin
                state_d.af  = 1'b0;
                state_d.rel = 1'b0;
            end
        end
        if (fire_w) begin
            state_d.af  = 1'b1;
            state_d.rel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (reg_sel == AW'(i)) reg_rdata = state_q.alm[i];
        end
        if (reg_sel == AW'(A_RPT))   reg_rdata = {{(DW-NF){1'b0}}, state_q.rpt};
        if (reg_sel == AW'(A_EN))    reg_rdata = {{(DW-2){1'b0}}, state_q.abe, state_q.afe};
        if (reg_sel == AW'(A_FLAGS)) reg_rdata[AF_BIT] = state_q.af;
    end

    assign irq_n = ~(state_q.af & ~state_q.rel & state_q.afe & (~backup | state_q.abe));
endmodule

// File: rtl/alm_match_unit_chk.sv
module alm_match_unit_chk
    import alm_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          backup,
    input logic [AW-1:0] reg_sel,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          irq_n,
    input logic          af,
    input logic          rel,
    input logic          afe,
    input logic          abe,
    input logic [DW-1:0] alm_date,
    input logic [NF-1:0] rpt
);
    logic flags_rd, flags_wr, en_wr, off_w;
    assign flags_rd = reg_rd && reg_sel == AW'(A_FLAGS);
    assign flags_wr = reg_wr && reg_sel == AW'(A_FLAGS);
    assign en_wr    = reg_wr && reg_sel == AW'(A_EN);
    assign off_w    = (alm_date == '0) && (rpt[NF-2:0] == '0);

    p_af_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(tick));
    p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (afe && af));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && af && !rel && !tick) |=> (irq_n && af));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && af && rel && !tick) |=> !af);
    p_backup_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (backup && !abe) |-> irq_n);
    p_enable_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afe) |-> $past(en_wr));
    p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && off_w && !af && !reg_wr) |=> !af);
    p_flags_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && !flags_rd && !tick) |=> $stable(af));
endmodule

bind alm_match_unit alm_match_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .backup   (backup),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .irq_n    (irq_n),
    .af       (state_q.af),
    .rel      (state_q.rel),
    .afe      (state_q.afe),
    .abe      (state_q.abe),
    .alm_date (state_q.alm[alm_pkg::F_DATE]),
    .rpt      (state_q.rpt)
);

// File: tb/alm_match_unit_bench.sv
`timescale 1ns/1ps
module alm_match_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       backup = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    alm_match_unit u_alm_match_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .backup(backup),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_sel = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        rd(a, v);
        check(v == e, tag, v, e);
    endtask

    task automatic set_time(input logic [7:0] mo, d, h, mi, s);
        cur_month = mo; cur_date = d; cur_hour = h; cur_min = mi; cur_sec = s;
    endtask

    task automatic do_tick(input logic [7:0] mo, d, h, mi, s);
        set_time(mo, d, h, mi, s);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_flag;
        logic [7:0] v;
        rd(3'd7, v);
        rd(3'd7, v);
    endtask

    task automatic load_alarm(input logic [7:0] mo, d, h, mi, s);
        wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, d); wr(3'd4, mo);
    endtask

    // probe one repeat code: fires on hit time, silent on miss time
    task automatic probe(input logic [4:0] code, input logic [39:0] hit, input logic [39:0] miss, input string tag);
        wr(3'd5, {3'b0, code});
        do_tick(hit[39:32], hit[31:24], hit[23:16], hit[15:8], hit[7:0]);
        expect_rd(3'd7, 8'h40, {tag, " hit"});
        rd(3'd7, reg_wdata);
        do_tick(miss[39:32], miss[31:24], miss[23:16], miss[15:8], miss[7:0]);
        expect_rd(3'd7, 8'h00, {tag, " miss"});
    endtask

    task automatic t_reset;
        check(irq_n == 1'b1, "R7 irq_n after reset", irq_n, 1);
        for (int a = 0; a < 8; a++) expect_rd(a[2:0], 8'h00, "R7 register reset value");
    endtask

    task automatic t_full_match;
        load_alarm(8'h06, 8'h21, 8'h08, 8'h15, 8'h30);
        wr(3'd5, 8'h00);
        do_tick(8'h06, 8'h21, 8'h08, 8'h15, 8'h30);
        check(irq_n == 1'b1, "R4 no irq while enable clear", irq_n, 1);
        expect_rd(3'd7, 8'h40, "R3 flag set on full match");
        expect_rd(3'd7, 8'h40, "R5 flag held after first read");
        expect_rd(3'd7, 8'h00, "R5 flag cleared by second read");
        do_tick(8'h07, 8'h21, 8'h08, 8'h15, 8'h30);
        expect_rd(3'd7, 8'h00, "R1 month mismatch under code 00000");
    endtask

    task automatic t_no_tick;
        set_time(8'h06, 8'h21, 8'h08, 8'h15, 8'h30);
        repeat (3) @(negedge clk);
        expect_rd(3'd7, 8'h00, "R9 no compare without tick");
    endtask

    task automatic t_repeat_codes;
        probe(5'b10000, {8'h09, 8'h21, 8'h08, 8'h15, 8'h30}, {8'h09, 8'h22, 8'h08, 8'h15, 8'h30}, "R1 code 10000");
        probe(5'b11000, {8'h09, 8'h05, 8'h08, 8'h15, 8'h30}, {8'h09, 8'h05, 8'h09, 8'h15, 8'h30}, "R1 code 11000");
        probe(5'b11100, {8'h09, 8'h05, 8'h11, 8'h15, 8'h30}, {8'h09, 8'h05, 8'h11, 8'h16, 8'h30}, "R1 code 11100");
        probe(5'b11110, {8'h09, 8'h05, 8'h11, 8'h42, 8'h30}, {8'h09, 8'h05, 8'h11, 8'h42, 8'h31}, "R1 code 11110");
        wr(3'd5, 8'h1f);
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        expect_rd(3'd7, 8'h40, "R1 code 11111 fires");
        rd(3'd7, reg_wdata);
    endtask

    task automatic t_bad_code;
        wr(3'd5, 8'h0a);
        do_tick(8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        expect_rd(3'd7, 8'h40, "R2 code 01010 fires every tick");
        rd(3'd7, reg_wdata);
        wr(3'd5, 8'h01);
        do_tick(8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
        expect_rd(3'd7, 8'h40, "R2 code 00001 fires every tick");
        rd(3'd7, reg_wdata);
    endtask

    task automatic t_irq_handshake;
        wr(3'd5, 8'h1f);
        wr(3'd6, 8'h01);
        expect_rd(3'd6, 8'h01, "R4 enable readback");
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h01);
        check(irq_n == 1'b0, "R4 irq asserted", irq_n, 0);
        expect_rd(3'd7, 8'h40, "R5 first read sees flag");
        check(irq_n == 1'b1, "R5 irq released by first read", irq_n, 1);
        expect_rd(3'd7, 8'h40, "R5 flag still set at second read");
        expect_rd(3'd7, 8'h00, "R5 flag clear after second read");
    endtask

    task automatic t_rearm;
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h02);
        rd(3'd7, reg_wdata);
        check(irq_n == 1'b1, "R9 released before re-arm", irq_n, 1);
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h03);
        check(irq_n == 1'b0, "R9 new match re-arms irq", irq_n, 0);
        clear_flag();
    endtask

    task automatic t_flags_write;
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h04);
        wr(3'd7, 8'h00);
        check(irq_n == 1'b0, "R10 flags write leaves irq", irq_n, 0);
        expect_rd(3'd7, 8'h40, "R10 flags write leaves flag");
        rd(3'd7, reg_wdata);
    endtask

    task automatic t_backup;
        backup = 1'b1;
        do_tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h05);
        check(irq_n == 1'b1, "R6 backup blocks irq without backup enable", irq_n, 1);
        wr(3'd6, 8'h03);
        check(irq_n == 1'b0, "R6 backup enable allows irq", irq_n, 0);
        backup = 1'b0;
        clear_flag();
        wr(3'd6, 8'h00);
    endtask

    task automatic t_disable;
        load_alarm(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        wr(3'd5, 8'h00);
        do_tick(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_rd(3'd7, 8'h00, "R8 zero date and repeat bits disable alarm");
        wr(3'd5, 8'h10);
        do_tick(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_rd(3'd7, 8'h00, "R8 month-ignore code still disabled");
        wr(3'd5, 8'h18);
        do_tick(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_rd(3'd7, 8'h40, "R8 date-ignore code re-enables");
        rd(3'd7, reg_wdata);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_match();
        t_no_tick();
        t_repeat_codes();
        t_bad_code();
        t_irq_handshake();
        t_rearm();
        t_flags_write();
        t_backup();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule